// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer on a simple 16-bit register bus. A fixed prescaler divides the system clock. Each prescaled tick decrements a live counter. Software keeps the counter from running out by writing a two-word key pair to the service register. Each completed pair reloads the counter from a programmable timeout limit. If the counter runs out, the block raises a reset request for one clock. It also leaves a sticky flag that firmware reads after restart to learn why the system was reset.

Counting can be paused while the processor is in a low-power or halted state. Each of the three state inputs has its own gate bit in the control register, so firmware chooses which states freeze the timer. The intended start-up order is:
1. Program the limit.
2. Set the enable bit.
3. Issue one key pair.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control register reads 0 (disabled), the limit reads 0xFFFF, the counter reads 0xFFFF, the status register reads 0 and `wdog_req` is low.
- R2: Registers sit at byte offsets 0 (control), 2 (limit), 4 (counter) and 6 (service on write, status on read). In control, bit 0 is enable, bit 1 gates on `cpu_halt`, bit 2 gates on `cpu_doze` and bit 3 gates on `cpu_wait`; bits 15:4 read as 0. The counter is read-only. Writes to the service offset never change the status value. An access with `bus_addr[0]` set writes nothing and reads 0.
- R3: While enabled and not gated, the counter drops by exactly one every PRESCALE clocks. The first drop comes PRESCALE clocks after the prescaler was last cleared.
- R4: A tick that finds the counter at 1 or 0 expires the timer. `wdog_req` is then high for exactly one clock, status bit 0 becomes 1, and the counter reloads from the limit.
- R5: Writing 0x5555 and then 0xAAAA as consecutive service writes reloads the counter from the limit on the second write and clears the prescaler.
- R6: A 0xAAAA that does not directly follow a 0x5555 service write does nothing. Any other value written after 0x5555 drops the pending half. A second 0x5555 restarts the pair.
- R7: A write to the limit does not change the counter. The new value is used at the next reload.
- R8: Counting freezes while a gate bit is set and its matching input is high. A set bit with its input low, or a high input with its bit clear, does not freeze counting.
- R9: Clearing enable freezes the counter and clears the prescaler. After enable is set again, the first drop comes exactly PRESCALE clocks later.
- R10: The status flag stays set through later key pairs until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| cpu_halt | input | 1 | Processor halted state |
| cpu_doze | input | 1 | Processor doze state |
| cpu_wait | input | 1 | Processor wait state |
| wdog_req | output | 1 | One-clock reset request on expiry |

## Verification
The bench counts clocks exactly around each tick. A prescaler that is off by one, or that is not cleared by a key pair or by clearing enable, moves the first counter drop by a cycle and is caught. It sends broken key sequences: a lone 0xAAAA, a wrong word between the two keys, and a doubled 0x5555. A detector that stays armed too long, or does not re-arm, reloads when it should not or misses a reload. Each gate bit is tried with its input high and with a mismatched input. Swapped or inverted gating then shows up as a frozen counter or a counter that keeps moving. Expiry at a small limit checks for a request longer than one clock, a missing sticky flag, and a missing reload.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int WD_W = 16;
    localparam logic [WD_W-1:0] KEY_ARM  = 16'h5555;
    localparam logic [WD_W-1:0] KEY_FIRE = 16'hAAAA;

    localparam int CTL_EN   = 0;
    localparam int CTL_HALT = 1;
    localparam int CTL_DOZE = 2;
    localparam int CTL_WAIT = 3;
    localparam int CTL_W    = 4;

    typedef enum logic [1:0] {
        RG_CTL  = 2'd0,
        RG_LIM  = 2'd1,
        RG_CNT  = 2'd2,
        RG_STAT = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic [WD_W-1:0]  limit;
        logic [WD_W-1:0]  count;
        logic             flag;
        logic             req;
    } wd_state_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRESCALE = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

    logic [PS_W-1:0] cnt_d, cnt_q;
    logic            at_end;

    generate
        if ((PRESCALE & (PRESCALE - 1)) == 0) begin : g_pow2
            assign at_end = &cnt_q;
        end else begin : g_generic
            assign at_end = (cnt_q == LAST);
        end
    endgenerate

    assign tick = run && at_end;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = at_end ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdog_key.sv
module wdog_key
    import wdog_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            svc_wr,
    input  logic [WD_W-1:0] wdata,
    output logic            hit
);
    logic armed_d, armed_q;

    assign hit = svc_wr && armed_q && (wdata == KEY_FIRE);

    always_comb begin
        armed_d = armed_q;
        if (svc_wr) armed_d = (wdata == KEY_ARM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int PRESCALE = 4096
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [2:0]      bus_addr,
    input  logic [WD_W-1:0] bus_wdata,
    output logic [WD_W-1:0] bus_rdata,
    input  logic            cpu_halt,
    input  logic            cpu_doze,
    input  logic            cpu_wait,
    output logic            wdog_req
);
    wd_state_t st_d, st_q;
    reg_idx_e  idx;
    logic      wr_ok, ctl_wr, lim_wr, svc_wr;
    logic      run, tick, svc_hit, pre_clr;
    logic [WD_W-1:0] count_v;
    logic            flag_v;

    assign idx    = reg_idx_e'(bus_addr[2:1]);
    assign wr_ok  = bus_sel && bus_we && !bus_addr[0];
    assign ctl_wr = wr_ok && (idx == RG_CTL);
    assign lim_wr = wr_ok && (idx == RG_LIM);
    assign svc_wr = wr_ok && (idx == RG_STAT);

    assign run = st_q.ctl[CTL_EN]
              && !(st_q.ctl[CTL_HALT] && cpu_halt)
              && !(st_q.ctl[CTL_DOZE] && cpu_doze)
              && !(st_q.ctl[CTL_WAIT] && cpu_wait);
    assign pre_clr = !st_q.ctl[CTL_EN] || svc_hit;

    wdog_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (pre_clr),
        .tick  (tick)
    );

    wdog_key u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .svc_wr (svc_wr),
        .wdata  (bus_wdata),
        .hit    (svc_hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (ctl_wr) st_d.ctl   = bus_wdata[CTL_W-1:0];
        if (lim_wr) st_d.limit = bus_wdata;
        if (svc_hit) begin
            st_d.count = st_q.limit;
        end else if (tick) begin
            if (st_q.count <= 16'd1) begin
                st_d.count = st_q.limit;
                st_d.req   = 1'b1;
                st_d.flag  = 1'b1;
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl   <= '0;
            st_q.limit <= '1;
            st_q.count <= '1;
            st_q.flag  <= 1'b0;
            st_q.req   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr[0]) begin
            unique case (idx)
                RG_CTL:  bus_rdata = {{(WD_W-CTL_W){1'b0}}, st_q.ctl};
                RG_LIM:  bus_rdata = st_q.limit;
                RG_CNT:  bus_rdata = st_q.count;
                RG_STAT: bus_rdata = {{(WD_W-1){1'b0}}, st_q.flag};
                default: bus_rdata = '0;
            endcase
        end
    end

    assign wdog_req = st_q.req;
    assign count_v  = st_q.count;
    assign flag_v   = st_q.flag;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        svc_hit,
    input logic [15:0] count_v,
    input logic        flag_v,
    input logic        wdog_req
);
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_req |=> !wdog_req); // R4
    AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_req |-> flag_v); // R4
    AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_req |-> $past(tick)); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_v |=> flag_v); // R10
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !svc_hit) |=> $stable(count_v)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !svc_hit && count_v > 16'd1) |=> (count_v == 16'($past(count_v) - 16'd1))); // R3
endmodule

bind wdog_timer wdog_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .svc_hit  (svc_hit),
    .count_v  (count_v),
    .flag_v   (flag_v),
    .wdog_req (wdog_req)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
    localparam int PS = 4096;
    localparam logic [2:0] A_CTL = 3'd0, A_LIM = 3'd2, A_CNT = 3'd4, A_SVC = 3'd6;

    typedef struct packed {
        logic [2:0]  addr;
        logic [15:0] wdata;
        logic [2:0]  raddr;
        logic [15:0] expd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 16'h00F0, 3'd0, 16'h0000},
        '{3'd0, 16'h000E, 3'd0, 16'h000E},
        '{3'd0, 16'h0000, 3'd0, 16'h0000},
        '{3'd2, 16'h1234, 3'd2, 16'h1234},
        '{3'd4, 16'h0042, 3'd4, 16'hFFFF},
        '{3'd6, 16'h0001, 3'd6, 16'h0000},
        '{3'd3, 16'h0077, 3'd2, 16'h1234},
        '{3'd2, 16'hBEEF, 3'd3, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic cpu_halt = 1'b0, cpu_doze = 1'b0, cpu_wait = 1'b0;
    logic wdog_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdog_timer #(.PRESCALE(PS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_halt(cpu_halt), .cpu_doze(cpu_doze), .cpu_wait(cpu_wait),
        .wdog_req(wdog_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expd);
        checks++;
        if (act !== expd) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expd);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic service();
        wr(A_SVC, 16'h5555);
        wr(A_SVC, 16'hAAAA);
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_cnt(input string req, input logic [15:0] expd);
        logic [15:0] v;
        rd(A_CNT, v);
        chk(req, v, expd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        wait_edges(3);
        rst_n = 1'b1;
        wait_edges(1);

        // R1 reset state
        rd(A_CTL, v); chk("R1 ctl", v, 16'h0000);
        rd(A_LIM, v); chk("R1 limit", v, 16'hFFFF);
        rd(A_CNT, v); chk("R1 count", v, 16'hFFFF);
        rd(A_SVC, v); chk("R1 status", v, 16'h0000);
        chk("R1 req", {15'b0, wdog_req}, 16'h0000);

        // R2 register map via vector table
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].addr, VEC[i].wdata);
            rd(VEC[i].raddr, v);
            chk($sformatf("R2 vector %0d", i), v, VEC[i].expd);
        end

        // R5 start-up and R3 stepping, R4 expiry
        wr(A_LIM, 16'd2);
        wr(A_CTL, 16'h0001);
        service();
        chk_cnt("R5 reload after pair", 16'd2);
        wait_edges(PS - 1);
        chk_cnt("R3 no drop before period", 16'd2);
        wait_edges(1);
        chk_cnt("R3 drop at period", 16'd1);
        wait_edges(PS - 1);
        chk("R4 req low before expiry", {15'b0, wdog_req}, 16'h0000);
        wait_edges(1);
        chk("R4 req high on expiry", {15'b0, wdog_req}, 16'h0001);
        rd(A_SVC, v); chk("R4 status flag", v, 16'h0001);
        chk_cnt("R4 reload on expiry", 16'd2);
        wait_edges(1);
        chk("R4 req one clock", {15'b0, wdog_req}, 16'h0000);

        // R10 sticky flag
        service();
        rd(A_SVC, v); chk("R10 flag survives service", v, 16'h0001);

        // R7 limit applied at next reload
        wr(A_LIM, 16'd5);
        chk_cnt("R7 count untouched by limit write", 16'd2);
        service();
        chk_cnt("R7 new limit on reload", 16'd5);

        // R6 broken sequences
        wait_edges(PS);
        chk_cnt("R6 setup drop", 16'd4);
        wr(A_SVC, 16'hAAAA);
        chk_cnt("R6 lone second key", 16'd4);
        wr(A_SVC, 16'h5555); wr(A_SVC, 16'h1234); wr(A_SVC, 16'hAAAA);
        chk_cnt("R6 wrong middle word", 16'd4);
        wr(A_SVC, 16'h5555); wr(A_SVC, 16'h5555); wr(A_SVC, 16'hAAAA);
        chk_cnt("R6 restart on repeated first key", 16'd5);

        // R8 gating
        wr(A_CTL, 16'h0003);
        cpu_halt = 1'b1;
        service();
        wait_edges(5000);
        chk_cnt("R8 halt gate freezes", 16'd5);
        cpu_halt = 1'b0;
        wait_edges(PS);
        chk_cnt("R8 halt released counts", 16'd4);
        wr(A_CTL, 16'h0005);
        cpu_doze = 1'b1;
        service();
        wait_edges(5000);
        chk_cnt("R8 doze gate freezes", 16'd5);
        wr(A_CTL, 16'h0001);
        service();
        wait_edges(PS);
        chk_cnt("R8 doze input without bit counts", 16'd4);
        cpu_doze = 1'b0;
        wr(A_CTL, 16'h0009);
        service();
        wait_edges(PS);
        chk_cnt("R8 wait bit without input counts", 16'd4);
        cpu_wait = 1'b1;
        service();
        wait_edges(3000);
        chk_cnt("R8 wait gate freezes", 16'd5);
        cpu_wait = 1'b0;

        // R9 disable freezes and clears prescaler
        wr(A_CTL, 16'h0001);
        service();
        wait_edges(2000);
        wr(A_CTL, 16'h0000);
        wait_edges(6000);
        chk_cnt("R9 disabled freezes", 16'd5);
        wr(A_CTL, 16'h0001);
        wait_edges(PS - 1);
        chk_cnt("R9 no early drop after enable", 16'd5);
        wait_edges(1);
        chk_cnt("R9 drop one period after enable", 16'd4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule